// File: doc/BRIEF.md
# Programmable Input Frame Phase Aligner

This block lines up the receive frame of a group of serial input lines against a frame sync pulse. It runs on a clock at twice the serial bit rate. A frame is a fixed number of 8-bit channels. For each line the block produces a sample strobe, shifts the sampled bits into bytes, and presents every completed byte with a one-cycle valid pulse and the channel it belongs to.

Even-numbered lines always use the standard timing: their frame position is zero in the cycle after the rising edge of sync. Odd-numbered lines can be shifted by the upper nibble of an 8-bit shift control word. Bits 7..5 give an advance of 0 to 7 whole bit periods. Bit 4 adds a delay of half a bit period. Together they place the odd-line frame at any half-bit step between 7 bits early and half a bit late. Bits 3..0 of the control word belong to other logic and are ignored here.

Frame position is counted in half-bit units. A position is sampled when its least significant bit is 1. Bits go out MSB first, and the byte index within the frame is the position divided by 16.

Top module: `frame_phase_aligner`

## Requirements
- R1: Bits 3..0 of `shift_cfg` have no effect on any output.
- R2: In the cycle after a sync rising edge, the odd-line half-bit position equals 2×`shift_cfg[7:5]` minus `shift_cfg[4]`, modulo the frame length. For example, 1100xxxx advances the odd-line frame by 6 bit periods, which is position 12.
- R3: `shift_cfg[4]`=1 delays the odd-line frame by half a bit. With 1001xxxx the net advance is 3.5 bit periods (position 7). With 0001xxxx the frame sits half a bit late (position 2×8×N_CHAN−1).
- R4: Even lines always take position 0 in the cycle after a sync rising edge, whatever the value of `shift_cfg`.
- R5: With `shift_cfg[7:4]`=0, odd and even lines have identical timing.
- R6: Between sync edges, each position counter steps by one per clock and wraps from 16×N_CHAN−1 to 0.
- R7: Only a rising edge of `sync_in` reloads the counters. Holding `sync_in` high for several cycles causes no further reload.
- R8: `smp_stb[l]` is 1 exactly when the line's position is odd. `ser_in[l]` is captured on the rising clock edge of that cycle, and bit index (position/2) mod 8 maps to bit 7 minus that index (MSB first).
- R9: One cycle after the strobe at a position with low nibble 15, `byte_vld[l]` pulses for one cycle. `byte_out` then holds the 8 captured bits and `chan_out` holds position/16.
- R10: While reset is applied, `smp_stb`, `byte_vld`, `byte_out` and `chan_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame sync; its rising edge reloads the frame counters |
| shift_cfg | input | 8 | Shift control word; only bits 7..4 are used |
| ser_in | input | N_LINES | Serial data, one bit per line |
| smp_stb | output | N_LINES | Per-line sample strobe |
| byte_vld | output | N_LINES | Per-line byte-complete pulse |
| byte_out | output | 8×N_LINES | Per-line last completed byte |
| chan_out | output | log2(N_CHAN)×N_LINES | Per-line channel index of that byte |

## Verification
The bench samples outputs on the falling clock edge. Counting the sync edge as the load edge, the k-th falling edge after it sees position offset+k. The strobe follows the position combinationally, so it is checked in that same half-cycle. A byte valid pulse and its data and channel come through one register, so each is checked one falling edge after the strobe of the byte's last bit. For every line the bench computes the expected position from the requirement formula and drives the serial stream from that same computed position. A wrong offset therefore shows up as wrong bytes or as a valid pulse at the wrong cycle. Byte contents are checked only after 16 positions have passed since the load, so that every checked byte was driven entirely after the sync edge.

// File: rtl/ifpa_pkg.sv
package ifpa_pkg;
  // Upper nibble of the shift control word.
  typedef struct packed {
    logic [2:0] adv;   // whole-bit advance
    logic       half;  // half-bit delay
  } shift_ctl_t;
endpackage

// File: rtl/ifpa_offset.sv
module ifpa_offset
  import ifpa_pkg::*;
#(
  parameter int PW   = 6,
  parameter int LAST = 63
) (
  input  shift_ctl_t    ctl,
  output logic [PW-1:0] odd_off
);
  logic [PW-1:0] adv_half;

  always_comb begin
    adv_half = PW'({ctl.adv, 1'b0});
    if (ctl.adv == 3'd0 && ctl.half)
      odd_off = PW'(LAST);
    else
      odd_off = adv_half - PW'(ctl.half);
  end
endmodule

// File: rtl/ifpa_frame_ctr.sv
module ifpa_frame_ctr #(
  parameter int PW   = 6,
  parameter int LAST = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic [PW-1:0] pos
);
  logic [PW-1:0] pos_q, pos_d;

  always_comb begin
    if (load)
      pos_d = load_val;
    else if (pos_q == PW'(LAST))
      pos_d = '0;
    else
      pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  // R6 wrap and step
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pos_q == PW'(LAST)) |=> pos_q == '0);
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pos_q != PW'(LAST)) |=> pos_q == $past(pos_q) + 1'b1);
  // R7 reload value
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pos_q == $past(load_val));
endmodule

// File: rtl/ifpa_deser.sv
module ifpa_deser #(
  parameter int PW  = 6,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PW-1:0]  pos,
  input  logic           din,
  output logic           stb,
  output logic           vld,
  output logic [7:0]     data,
  output logic [CHW-1:0] chan
);
  logic [6:0]     sh_q, sh_d;
  logic [7:0]     data_q, data_d;
  logic [CHW-1:0] chan_q, chan_d;
  logic           vld_q, vld_d;
  logic           last;

  always_comb begin
    stb    = pos[0];
    last   = stb && (pos[3:1] == 3'd7);
    sh_d   = stb  ? {sh_q[5:0], din} : sh_q;
    vld_d  = last;
    data_d = last ? {sh_q, din} : data_q;
    chan_d = last ? pos[PW-1:4] : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
      chan_q <= '0;
    end else begin
      sh_q   <= sh_d;
      vld_q  <= vld_d;
      data_q <= data_d;
      chan_q <= chan_d;
    end
  end

  assign vld  = vld_q;
  assign data = data_q;
  assign chan = chan_q;
endmodule

// File: rtl/frame_phase_aligner.sv
module frame_phase_aligner
  import ifpa_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int N_CHAN  = 4,
  localparam int FB     = N_CHAN * 8,
  localparam int LAST   = 2 * FB - 1,
  localparam int PW     = $clog2(2 * FB),
  localparam int CHW    = $clog2(N_CHAN)
) (
  input  logic                     clk2x,
  input  logic                     rst_n,
  input  logic                     sync_in,
  input  logic [7:0]               shift_cfg,
  input  logic [N_LINES-1:0]       ser_in,
  output logic [N_LINES-1:0]       smp_stb,
  output logic [N_LINES-1:0]       byte_vld,
  output logic [N_LINES*8-1:0]     byte_out,
  output logic [N_LINES*CHW-1:0]   chan_out
);
  logic [1:0]    rst_pipe;
  logic          rst_i_n;
  logic          sync_q;
  logic          sync_rise;
  logic [PW-1:0] odd_off;
  logic [PW-1:0] grp_pos [2];
  shift_ctl_t    ctl;
  logic          unused_low;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  always_ff @(posedge clk2x or negedge rst_i_n) begin
    if (!rst_i_n) sync_q <= 1'b1;
    else          sync_q <= sync_in;
  end
  assign sync_rise = sync_in & ~sync_q;

  assign ctl        = shift_ctl_t'(shift_cfg[7:4]);
  assign unused_low = ^shift_cfg[3:0];

  ifpa_offset #(.PW(PW), .LAST(LAST)) u_off (
    .ctl     (ctl),
    .odd_off (odd_off)
  );

  // Group 0 serves even lines, group 1 odd lines.
  for (genvar g = 0; g < 2; g++) begin : g_grp
    ifpa_frame_ctr #(.PW(PW), .LAST(LAST)) u_ctr (
      .clk      (clk2x),
      .rst_n    (rst_i_n),
      .load     (sync_rise),
      .load_val ((g == 1) ? odd_off : '0),
      .pos      (grp_pos[g])
    );
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    ifpa_deser #(.PW(PW), .CHW(CHW)) u_des (
      .clk   (clk2x),
      .rst_n (rst_i_n),
      .pos   (grp_pos[l % 2]),
      .din   (ser_in[l]),
      .stb   (smp_stb[l]),
      .vld   (byte_vld[l]),
      .data  (byte_out[l*8 +: 8]),
      .chan  (chan_out[l*CHW +: CHW])
    );
  end

  // R4 even lines take the standard position
  a_r4_even_zero: assert property (@(posedge clk2x) disable iff (!rst_i_n)
    sync_rise |=> grp_pos[0] == '0);
  // R5 zero nibble aligns odd and even
  a_r5_same_timing: assert property (@(posedge clk2x) disable iff (!rst_i_n)
    (sync_rise && shift_cfg[7:4] == 4'h0) |=> grp_pos[0] == grp_pos[1]);
endmodule

// File: tb/sim_frame_phase_aligner.sv
`timescale 1ns/1ps
module sim_frame_phase_aligner;
  localparam int NL  = 4;
  localparam int NC  = 4;
  localparam int FL  = NC * 16;   // half-bit positions per frame
  localparam int CHW = 2;
  localparam int NV  = 8;

  // Stimulus table: control word, expected odd-line position after load, sync hold.
  localparam logic [7:0] V_CFG  [NV] = '{8'h00, 8'hC0, 8'hCF, 8'h90, 8'h10, 8'hE7, 8'h3A, 8'h05};
  localparam int         V_OFF  [NV] = '{0,     12,    12,    7,     63,    14,    1,     0};
  localparam int         V_HOLD [NV] = '{1,     1,     1,     1,     3,     1,     2,     4};

  logic                clk2x = 1'b0;
  logic                rst_n;
  logic                sync_in;
  logic [7:0]          shift_cfg;
  logic [NL-1:0]       ser_in;
  logic [NL-1:0]       smp_stb;
  logic [NL-1:0]       byte_vld;
  logic [NL*8-1:0]     byte_out;
  logic [NL*CHW-1:0]   chan_out;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk2x = ~clk2x;

  frame_phase_aligner #(.N_LINES(NL), .N_CHAN(NC)) u0 (
    .clk2x(clk2x), .rst_n(rst_n), .sync_in(sync_in), .shift_cfg(shift_cfg),
    .ser_in(ser_in), .smp_stb(smp_stb), .byte_vld(byte_vld),
    .byte_out(byte_out), .chan_out(chan_out)
  );

  function automatic logic [7:0] pat(int l, int c);
    return 8'(8'h3C + l * 81 + c * 23);
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One vector: pulse sync with the given control word, then run two frames.
  task automatic run_vec(logic [7:0] cfg, int off, int hold, string tag);
    @(negedge clk2x);
    shift_cfg = cfg;
    sync_in   = 1'b1;
    ser_in    = '0;
    for (int k = 0; k < 2 * FL + 2; k++) begin
      @(negedge clk2x);
      if (k >= hold - 1) sync_in = 1'b0;
      for (int l = 0; l < NL; l++) begin
        int base = (l % 2 == 1) ? off : 0;
        int p    = (base + k) % FL;
        int pp   = (base + k - 1 + FL) % FL;
        logic [7:0] b;
        // R8 strobe on odd positions
        chk((l % 2 == 1) ? tag : "R4", int'(smp_stb[l]), p % 2, $sformatf("R8 strobe line %0d k %0d", l, k));
        if (k >= 1) begin
          if (pp % 16 == 15) begin
            // R9 valid, channel, data
            chk(tag, int'(byte_vld[l]), 1, $sformatf("R9 valid line %0d k %0d", l, k));
            chk(tag, int'(chan_out[l*CHW +: CHW]), pp / 16, $sformatf("R9 channel line %0d", l));
            if (k >= 17)
              chk(tag, int'(byte_out[l*8 +: 8]), int'(pat(l, pp / 16)), $sformatf("R9 data line %0d", l));
          end else if (byte_vld[l]) begin
            chk(tag, 1, 0, $sformatf("R9 stray valid line %0d k %0d", l, k));
          end
        end
        b = pat(l, p / 16);
        ser_in[l] = b[7 - (p / 2) % 8];
      end
    end
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    sync_in   = 1'b0;
    shift_cfg = 8'h00;
    ser_in    = '0;
    repeat (3) @(negedge clk2x);
    // R10 reset state
    chk("R10", int'(smp_stb),  0, "strobe in reset");
    chk("R10", int'(byte_vld), 0, "valid in reset");
    chk("R10", int'(byte_out), 0, "data in reset");
    chk("R10", int'(chan_out), 0, "channel in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk2x);

    // Table walk: R5 (00), R2 (C0), R1 (CF), R3 (90, 10), R7 (held sync), R6 wrap over two frames
    for (int v = 0; v < NV; v++) begin
      string tg;
      case (v)
        0: tg = "R5";
        1: tg = "R2";
        2: tg = "R1";
        3: tg = "R3";
        4: tg = "R7";
        5: tg = "R2";
        6: tg = "R3";
        default: tg = "R6";
      endcase
      run_vec(V_CFG[v], V_OFF[v], V_HOLD[v], tg);
    end

    // Directed: reset in mid-frame clears outputs again (R10)
    @(negedge clk2x);
    rst_n = 1'b0;
    @(negedge clk2x);
    chk("R10", int'(byte_vld), 0, "valid after mid-run reset");
    chk("R10", int'(smp_stb),  0, "strobe after mid-run reset");
    chk("R10", int'(byte_out), 0, "data after mid-run reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk2x);
    // Low nibble change alone with zero nibble: both groups aligned (R1, R5)
    run_vec(8'h0F, 0, 1, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule